// File: doc/BRIEF.md
# Automatic Flash Status Polling Engine

This engine lives inside a serial flash controller and takes the status-wait loop off the CPU. Once launched, it asks the command sequencer for a status read again and again. Each returned status word is compared with a programmable match value, and only the bit positions selected by a programmable mask take part. A pause of programmable length separates one read from the next.

When a compare succeeds, the engine sets a sticky match flag. It can also raise an interrupt, and it can halt by itself on that first hit. Software sets the engine up through a small write-only register port: control, mask, match, interval, flag clear, and a command register that launches or aborts polling. The serial sequencer is represented by a request/acknowledge handshake. The engine raises `cmd_req`, and the sequencer answers with one `cmd_ack` pulse that carries the status word.

Top module: `autopoll_engine`

Register offsets on `reg_addr`:
- 0: control. Bit 0 is the match interrupt enable. Bit 1 is auto-stop. Bit 2 is the length (0 for one byte, 1 for two bytes). Bits 5:4 are the functional mode: 0 write, 1 read, 2 auto-poll, 3 mapped.
- 1: mask.
- 2: match.
- 3: interval.
- 4: flag clear.
- 5: command. Bit 0 launches polling and bit 1 aborts it.

## Requirements
- R1: After reset the match flag, irq, busy and cmd_req are all 0, and the control, mask, match and interval registers are 0.
- R2: In two-byte mode, a response sets the match flag when (status & mask) == (match & mask) over all 16 bits. A differing bit that the mask selects prevents the set.
- R3: The length bit (control bit 2) appears on `cmd_two_bytes`. In one-byte mode, only bits 7:0 of mask, match and status are compared.
- R4: The match flag is sticky: later responses that do not match leave it set.
- R5: `irq` is high exactly when the flag is set and control bit 0 is 1. Clearing bit 0 drops `irq` and leaves the flag set.
- R6: With auto-stop (control bit 1) set, a matching response ends polling. In the cycle after the acknowledge, `busy` and `cmd_req` are 0, and no further request follows.
- R7: With auto-stop clear, polling continues after a matching response.
- R8: After each non-stopping response, `cmd_req` stays low for exactly the programmed interval in clock cycles and then rises again. An interval of 0 re-issues the request in the very next cycle.
- R9: Writing a word with bit 3 set to offset 4 clears the flag. Writing a word with bit 3 clear has no effect on the flag.
- R10: If a matching response and a flag-clear write occur in the same cycle, the flag stays set.
- R11: A launch raises `busy` and `cmd_req` in the cycle after the write, but only while the mode field is 2 (auto-poll). In any other mode, a launch leaves the engine idle.
- R12: An abort (command bit 1) returns the engine to idle in the next cycle from any state. An acknowledge that arrives in the same cycle as the abort is ignored and does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| cmd_req | output | 1 | Status-read request to the sequencer |
| cmd_two_bytes | output | 1 | Read length: 1 = two bytes, 0 = one byte |
| cmd_ack | input | 1 | Sequencer response valid (one-cycle pulse) |
| cmd_status | input | 16 | Status word returned with `cmd_ack` |
| busy | output | 1 | Polling active |
| match_flag | output | 1 | Sticky status-match flag |
| irq | output | 1 | Match interrupt request |

## Verification
Each result has a fixed due cycle:
- A register write, launch or abort shows on `busy`, `cmd_req` or the flag one clock after the edge that captures it.
- A response changes the flag, `busy` and `cmd_req` one clock after the edge that takes the acknowledge.
- `irq` follows the flag and the enable bit in the same cycle.

The bench drives inputs on the falling edge and samples on the following falling edges, so every check falls exactly one edge after its cause. For the interval, it counts the falling edges on which `cmd_req` is low and checks that the request returns on the edge that follows the last of them.

// File: rtl/apoll_pkg.sv
package apoll_pkg;

    localparam int ADDR_W   = 3;
    localparam int CLR_BIT  = 3;
    localparam int GO_BIT   = 0;
    localparam int STOP_BIT = 1;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 3'd0,
        RA_MASK  = 3'd1,
        RA_MATCH = 3'd2,
        RA_GAP   = 3'd3,
        RA_FCLR  = 3'd4,
        RA_CMD   = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        FM_WRITE    = 2'd0,
        FM_READ     = 2'd1,
        FM_AUTOPOLL = 2'd2,
        FM_MAPPED   = 2'd3
    } fmode_e;

    typedef struct packed {
        fmode_e mode;
        logic   two_bytes;
        logic   auto_stop;
        logic   match_ie;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_GAP   = 2'd2
    } pstate_e;

    function automatic ctrl_t decode_ctrl(input logic [15:0] w);
        ctrl_t c;
        c.match_ie  = w[0];
        c.auto_stop = w[1];
        c.two_bytes = w[2];
        c.mode      = fmode_e'(w[5:4]);
        return c;
    endfunction

endpackage

// File: rtl/apoll_regs.sv
module apoll_regs
    import apoll_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int GAP_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    input  logic              match_evt,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] match,
    output logic [GAP_W-1:0]  gap,
    output logic              go,
    output logic              abort_req,
    output logic              flag,
    output logic              irq
);

    logic clr;
    logic cmd_wr;

    assign cmd_wr    = reg_we && (reg_addr == RA_CMD);
    assign go        = cmd_wr && reg_wdata[GO_BIT];
    assign abort_req = cmd_wr && reg_wdata[STOP_BIT];
    assign clr       = reg_we && (reg_addr == RA_FCLR) && reg_wdata[CLR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            mask  <= '0;
            match <= '0;
            gap   <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RA_CTRL:  ctrl  <= decode_ctrl(reg_wdata);
                RA_MASK:  mask  <= DATA_W'(reg_wdata);
                RA_MATCH: match <= DATA_W'(reg_wdata);
                RA_GAP:   gap   <= GAP_W'(reg_wdata);
                default:  ;
            endcase
        end
    end

    // set wins over clear
    always_ff @(posedge clk) begin
        if (rst)            flag <= 1'b0;
        else if (match_evt) flag <= 1'b1;
        else if (clr)       flag <= 1'b0;
    end

    assign irq = flag & ctrl.match_ie;

    p_flag_set_r2: assert property (@(posedge clk) disable iff (rst)
        match_evt |=> flag);
    p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (clr && !match_evt) |=> !flag);
    p_set_beats_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (clr && match_evt) |=> flag);

endmodule

// File: rtl/apoll_cmp.sv
module apoll_cmp #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] mask,
    input  logic [DATA_W-1:0] match,
    input  logic              two_bytes,
    output logic              hit
);

    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0] lane_bad;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic       lane_on;
        logic [7:0] diff;
        assign lane_on     = (i == 0) || two_bytes;
        assign diff        = (status[i*8 +: 8] ^ match[i*8 +: 8]) & mask[i*8 +: 8];
        assign lane_bad[i] = lane_on && (|diff);
    end

    assign hit = ~|lane_bad;

endmodule

// File: rtl/apoll_fsm.sv
module apoll_fsm
    import apoll_pkg::*;
#(
    parameter int GAP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             abort_req,
    input  logic             mode_ok,
    input  logic             auto_stop,
    input  logic [GAP_W-1:0] gap,
    input  logic             cmd_ack,
    input  logic             hit,
    output logic             cmd_req,
    output logic             busy,
    output logic             match_evt
);

    pstate_e          state;
    logic [GAP_W-1:0] cnt;
    logic             resp;

    assign resp      = (state == ST_ISSUE) && cmd_ack && !abort_req;
    assign match_evt = resp && hit;
    assign cmd_req   = (state == ST_ISSUE);
    assign busy      = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (abort_req) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (go && mode_ok) state <= ST_ISSUE;
                ST_ISSUE: if (cmd_ack) begin
                    if (hit && auto_stop)   state <= ST_IDLE;
                    else if (gap == '0)     state <= ST_ISSUE;
                    else begin
                        state <= ST_GAP;
                        cnt   <= gap;
                    end
                end
                ST_GAP: begin
                    if (cnt == GAP_W'(1)) state <= ST_ISSUE;
                    else                  cnt   <= cnt - GAP_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_abort_idle_r12: assert property (@(posedge clk) disable iff (rst)
        abort_req |=> (state == ST_IDLE));
    p_autostop_r6: assert property (@(posedge clk) disable iff (rst)
        (resp && hit && auto_stop) |=> (state == ST_IDLE));
    p_gap_load_r8: assert property (@(posedge clk) disable iff (rst)
        (resp && !(hit && auto_stop) && gap != '0) |=>
            (state == ST_GAP && cnt == $past(gap)));
    p_mode_gate_r11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && go && !mode_ok) |=> (state == ST_IDLE));
    p_continue_r7: assert property (@(posedge clk) disable iff (rst)
        (resp && !auto_stop) |=> busy);

endmodule

// File: rtl/autopoll_engine.sv
module autopoll_engine
    import apoll_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int GAP_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic              cmd_req,
    output logic              cmd_two_bytes,
    input  logic              cmd_ack,
    input  logic [DATA_W-1:0] cmd_status,
    output logic              busy,
    output logic              match_flag,
    output logic              irq
);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] match;
    logic [GAP_W-1:0]  gap;
    logic              go;
    logic              abort_req;
    logic              match_evt;
    logic              hit;

    apoll_regs #(.DATA_W(DATA_W), .GAP_W(GAP_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .match_evt (match_evt),
        .ctrl      (ctrl),
        .mask      (mask),
        .match     (match),
        .gap       (gap),
        .go        (go),
        .abort_req (abort_req),
        .flag      (match_flag),
        .irq       (irq)
    );

    apoll_cmp #(.DATA_W(DATA_W)) u_cmp (
        .status    (cmd_status),
        .mask      (mask),
        .match     (match),
        .two_bytes (ctrl.two_bytes),
        .hit       (hit)
    );

    apoll_fsm #(.GAP_W(GAP_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .abort_req (abort_req),
        .mode_ok   (ctrl.mode == FM_AUTOPOLL),
        .auto_stop (ctrl.auto_stop),
        .gap       (gap),
        .cmd_ack   (cmd_ack),
        .hit       (hit),
        .cmd_req   (cmd_req),
        .busy      (busy),
        .match_evt (match_evt)
    );

    assign cmd_two_bytes = ctrl.two_bytes;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !cmd_req);

endmodule

// File: tb/autopoll_engine_test.sv
`timescale 1ns/1ps
module autopoll_engine_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic        cmd_req, cmd_two_bytes, cmd_ack;
    logic [15:0] cmd_status;
    logic        busy, match_flag, irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    autopoll_engine uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cmd_req(cmd_req), .cmd_two_bytes(cmd_two_bytes),
        .cmd_ack(cmd_ack), .cmd_status(cmd_status), .busy(busy),
        .match_flag(match_flag), .irq(irq)
    );

    localparam logic [2:0] A_CTRL = 3'd0, A_MASK = 3'd1, A_MATCH = 3'd2,
                           A_GAP = 3'd3, A_FCLR = 3'd4, A_CMD = 3'd5;

    function automatic logic [15:0] cw(input logic ie, input logic as,
                                       input logic two, input logic [1:0] md);
        return {10'd0, md, 1'b0, two, as, ie};
    endfunction

    function automatic logic exp_hit(input logic [15:0] st, input logic [15:0] mk,
                                     input logic [15:0] mt, input logic two);
        logic [15:0] m;
        m = two ? mk : (mk & 16'h00FF);
        return ((st ^ mt) & m) == 16'h0000;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic serve(input logic [15:0] st);
        int n = 0;
        while (!cmd_req && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk("R11 request seen", cmd_req, 1'b1);
        cmd_ack = 1'b1; cmd_status = st;
        @(negedge clk);
        cmd_ack = 1'b0;
    endtask

    task automatic stop_and_clear();
        wr(A_CMD, 16'h0002);
        wr(A_FCLR, 16'h0008);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] mk, mt, st;
        logic two, e;
        void'($urandom(1234));
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        cmd_ack = 1'b0; cmd_status = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 flag", match_flag, 1'b0);
        chk("R1 irq", irq, 1'b0);
        chk("R1 busy", busy, 1'b0);
        chk("R1 cmd_req", cmd_req, 1'b0);
        chk("R1 two_bytes", cmd_two_bytes, 1'b0);

        // R11 launch outside auto-poll mode is ignored
        wr(A_CTRL, cw(0, 1, 1, 2'd1));
        wr(A_CMD, 16'h0001);
        chk("R11 wrong mode busy", busy, 1'b0);
        chk("R11 wrong mode req", cmd_req, 1'b0);

        // R2 / R6 / R8: two-byte compare, nonmatch then match with auto-stop
        wr(A_MASK, 16'hF00F);
        wr(A_MATCH, 16'hA005);
        wr(A_GAP, 16'd3);
        wr(A_CTRL, cw(1, 1, 1, 2'd2));
        chk("R3 two_bytes out", cmd_two_bytes, 1'b1);
        wr(A_CMD, 16'h0001);
        chk("R11 launch busy", busy, 1'b1);
        chk("R11 launch req", cmd_req, 1'b1);
        serve(16'hB005);
        chk("R2 masked high nibble differs", match_flag, 1'b0);
        for (int k = 0; k < 3; k++) begin
            chk("R8 gap low", cmd_req, 1'b0);
            @(negedge clk);
        end
        chk("R8 gap end", cmd_req, 1'b1);
        serve(16'hA7F5);
        chk("R2 match ignoring unmasked", match_flag, 1'b1);
        chk("R5 irq with enable", irq, 1'b1);
        chk("R6 stop busy", busy, 1'b0);
        chk("R6 stop req", cmd_req, 1'b0);
        repeat (5) @(negedge clk);
        chk("R6 no further req", cmd_req, 1'b0);

        // R5 enable off drops irq, keeps flag
        wr(A_CTRL, cw(0, 1, 1, 2'd2));
        chk("R5 irq off", irq, 1'b0);
        chk("R5 flag kept", match_flag, 1'b1);

        // R9 clear semantics
        wr(A_FCLR, 16'h0000);
        chk("R9 zero write", match_flag, 1'b1);
        wr(A_FCLR, 16'hFFF7);
        chk("R9 bit3 clear write", match_flag, 1'b1);
        wr(A_FCLR, 16'h0008);
        chk("R9 clear", match_flag, 1'b0);

        // R3 one-byte compare ignores high byte
        wr(A_MASK, 16'hFFFF);
        wr(A_MATCH, 16'h1203);
        wr(A_CTRL, cw(0, 1, 0, 2'd2));
        chk("R3 one byte out", cmd_two_bytes, 1'b0);
        wr(A_CMD, 16'h0001);
        serve(16'hEE03);
        chk("R3 low byte match", match_flag, 1'b1);
        wr(A_FCLR, 16'h0008);

        // R7 / R4 / R8-zero / R10: continuous polling
        wr(A_GAP, 16'd0);
        wr(A_CTRL, cw(0, 0, 1, 2'd2));
        wr(A_CMD, 16'h0001);
        serve(16'h1203);
        chk("R7 match continues busy", busy, 1'b1);
        chk("R8 zero gap req", cmd_req, 1'b1);
        serve(16'h0000);
        chk("R4 sticky after nonmatch", match_flag, 1'b1);
        chk("R7 still polling", busy, 1'b1);
        // R10 match and clear together
        cmd_ack = 1'b1; cmd_status = 16'h1203;
        reg_we = 1'b1; reg_addr = A_FCLR; reg_wdata = 16'h0008;
        @(negedge clk);
        cmd_ack = 1'b0; reg_we = 1'b0;
        chk("R10 set beats clear", match_flag, 1'b1);

        // R12 abort with a response in the same cycle
        wr(A_FCLR, 16'h0008);
        chk("R9 clear idle", match_flag, 1'b0);
        cmd_ack = 1'b1; cmd_status = 16'h1203;
        reg_we = 1'b1; reg_addr = A_CMD; reg_wdata = 16'h0002;
        @(negedge clk);
        cmd_ack = 1'b0; reg_we = 1'b0;
        chk("R12 abort busy", busy, 1'b0);
        chk("R12 ack ignored", match_flag, 1'b0);

        // R12 abort during gap
        wr(A_GAP, 16'd50);
        wr(A_CMD, 16'h0001);
        serve(16'h0000);
        chk("R12 in gap", busy, 1'b1);
        wr(A_CMD, 16'h0002);
        chk("R12 abort from gap", busy, 1'b0);

        // Random compares (R2, R3, R6)
        wr(A_GAP, 16'd2);
        for (int i = 0; i < 40; i++) begin
            mk = 16'($urandom); mt = 16'($urandom);
            st = 16'($urandom);
            two = 1'($urandom);
            if (($urandom % 2) == 0) st = (mt & mk) | (st & ~mk);
            e = exp_hit(st, mk, mt, two);
            wr(A_MASK, mk);
            wr(A_MATCH, mt);
            wr(A_CTRL, cw(1, 1, two, 2'd2));
            wr(A_CMD, 16'h0001);
            serve(st);
            chk(two ? "R2 random flag" : "R3 random flag", match_flag, e);
            chk("R6 random busy", busy, !e);
            stop_and_clear();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule